// File: doc/BRIEF.md
# PS/2 Mouse Movement Report Decoder

This block listens to the two-wire serial stream a PS/2 mouse sends to its host and turns each three-byte movement report into parallel outputs. It brings the mouse clock and data lines into the system clock domain and takes a data bit on every falling edge of the mouse clock. It groups those bits into 11-bit frames and checks each frame's start bit, stop bit and odd parity. Three good frames in a row form one report.

The first byte of a report is a status byte. It gives the two button states, the sign of each movement and the two overflow flags. The second byte is the X magnitude and the third is the Y magnitude. The block joins each sign bit to its magnitude byte to form a 9-bit two's-complement delta, where right and up are positive. It pulses a valid strobe for one cycle when a report is complete and holds the decoded fields until the next good report.

The block recovers from bad input in three ways:
- A frame with a bad parity, start or stop bit throws away the whole report in progress.
- A first byte whose bit 3 is not set is taken as a sign that the block is out of step with the reports. That byte is dropped and the next byte is treated as a status byte.
- A long quiet period on the mouse clock clears both the bit count and the byte count, so the next edge starts a fresh frame and a fresh report.

Top module: `ps2_mouse_pkt_dec`

## Requirements
- R1: A frame is 11 bits, each taken on a falling edge of the mouse clock: a start bit of 0, then eight data bits with the least significant first, then a parity bit that makes the count of ones in data plus parity odd, then a stop bit of 1.
- R2: In the status byte, bit 0 drives `left_btn` and bit 1 drives `right_btn`. A 1 means the button is held.
- R3: `delta_x` is status bit 4 followed by the second byte, and `delta_y` is status bit 5 followed by the third byte. Each is read as a 9-bit two's-complement value, so a sign bit of 1 means negative.
- R4: `ovf_x` takes status bit 6 and `ovf_y` takes status bit 7.
- R5: `pkt_valid` is high for exactly one clock cycle per complete good report. All decoded outputs change only in that cycle and hold their values otherwise.
- R6: A frame whose parity is wrong discards the report in progress. No strobe is raised, the outputs keep their old values, and the next frame is taken as a status byte.
- R7: A frame whose start bit is 1 or whose stop bit is 0 is handled in the same way as in R6.
- R8: A good frame that arrives in the status position with bit 3 equal to 0 is dropped, and the next frame is again taken as a status byte.
- R9: If `GAP_CYCLES` system clock cycles pass with no falling edge on the mouse clock, the bit count and the byte position both return to the start.
- R10: After reset, every decoded output is 0 and `pkt_valid` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ps2_clk_i | input | 1 | Mouse clock line, asynchronous, idles high |
| ps2_dat_i | input | 1 | Mouse data line, asynchronous, idles high |
| left_btn | output | 1 | Left button held |
| right_btn | output | 1 | Right button held |
| delta_x | output | 9 | Signed X movement |
| delta_y | output | 9 | Signed Y movement |
| ovf_x | output | 1 | X movement overflowed |
| ovf_y | output | 1 | Y movement overflowed |
| pkt_valid | output | 1 | One-cycle strobe when a new report is on the outputs |

## Verification
The assertions check, on every cycle, the rules that tie internal events together:
- a frame-done strobe comes only right after a mouse-clock fall;
- a quiet-period strobe clears the bit count and the byte position;
- a bad frame or an out-of-step status byte sends assembly back to the status position;
- the valid strobe lasts one cycle, comes only from the third byte, and the outputs do not move outside it.

Only the bench's scenarios can show that the decoded values are right. Those scenarios cover bit order, field positions, sign extension of negative movement, and overflow flags. They also show that the output ports stay the same after a bad parity bit, a bad stop bit, a stray byte or an interrupted frame, and that decoding comes back correctly once good reports resume.

// File: rtl/mpkt_pkg.sv
package mpkt_pkg;
  localparam int DATA_BITS  = 8;
  localparam int FRAME_BITS = DATA_BITS + 3;
  localparam int DELTA_BITS = DATA_BITS + 1;

  // status byte field positions
  localparam int ST_LEFT  = 0;
  localparam int ST_RIGHT = 1;
  localparam int ST_SYNC  = 3;
  localparam int ST_XSIGN = 4;
  localparam int ST_YSIGN = 5;
  localparam int ST_XOVF  = 6;
  localparam int ST_YOVF  = 7;

  typedef enum logic [1:0] {SLOT_STAT = 2'd0, SLOT_X = 2'd1, SLOT_Y = 2'd2} slot_e;

  // frame bits after full shift: [0]=start, [8:1]=data, [9]=parity, [10]=stop
  function automatic logic odd_ok(input logic [DATA_BITS-1:0] d, input logic p);
    return ^{d, p};
  endfunction

  function automatic logic frame_ok(input logic [FRAME_BITS-1:0] f);
    return (f[0] == 1'b0) && (f[FRAME_BITS-1] == 1'b1) &&
           odd_ok(f[DATA_BITS:1], f[DATA_BITS+1]);
  endfunction

  function automatic logic [DELTA_BITS-1:0] to_delta(input logic sgn,
                                                     input logic [DATA_BITS-1:0] mag);
    return {sgn, mag};
  endfunction
endpackage

// File: rtl/mpkt_line_sync.sv
module mpkt_line_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ps2_clk,
  input  logic ps2_dat,
  output logic clk_fall,
  output logic dat_s
);
  logic [SYNC_STAGES-1:0] c_pipe, d_pipe;
  logic c_prev;

  for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          c_pipe[0] <= 1'b1;
          d_pipe[0] <= 1'b1;
        end else begin
          c_pipe[0] <= ps2_clk;
          d_pipe[0] <= ps2_dat;
        end
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          c_pipe[i] <= 1'b1;
          d_pipe[i] <= 1'b1;
        end else begin
          c_pipe[i] <= c_pipe[i-1];
          d_pipe[i] <= d_pipe[i-1];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) c_prev <= 1'b1;
    else        c_prev <= c_pipe[SYNC_STAGES-1];
  end

  assign clk_fall = c_prev & ~c_pipe[SYNC_STAGES-1];
  assign dat_s    = d_pipe[SYNC_STAGES-1];

  AST_FALL_NOT_TWICE: assert property (@(posedge clk) disable iff (!rst_n)
    clk_fall |=> !clk_fall); // R1
endmodule

// File: rtl/mpkt_frame_rx.sv
module mpkt_frame_rx
  import mpkt_pkg::*;
#(
  parameter int GAP_CYCLES = 200000
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clk_fall,
  input  logic                 dat_s,
  output logic                 frame_stb,
  output logic                 frame_err,
  output logic [DATA_BITS-1:0] frame_byte,
  output logic                 gap_stb
);
  localparam int CW = $clog2(FRAME_BITS);
  localparam int GW = $clog2(GAP_CYCLES + 1);
  localparam logic [CW-1:0] LAST_BIT = CW'(FRAME_BITS - 1);
  localparam logic [GW-1:0] GAP_LAST = GW'(GAP_CYCLES - 1);
  localparam logic [GW-1:0] GAP_SAT  = GW'(GAP_CYCLES);

  logic [CW-1:0]         bit_idx;
  logic [FRAME_BITS-1:0] shreg, shreg_nx;
  logic [GW-1:0]         idle_cnt;

  assign shreg_nx = {dat_s, shreg[FRAME_BITS-1:1]};
  assign gap_stb  = (idle_cnt == GAP_LAST) && !clk_fall;

  always_ff @(posedge clk) begin
    if (!rst_n)                   idle_cnt <= '0;
    else if (clk_fall)            idle_cnt <= '0;
    else if (idle_cnt != GAP_SAT) idle_cnt <= idle_cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bit_idx    <= '0;
      shreg      <= '0;
      frame_stb  <= 1'b0;
      frame_err  <= 1'b0;
      frame_byte <= '0;
    end else begin
      frame_stb <= 1'b0;
      if (clk_fall) begin
        shreg <= shreg_nx;
        if (bit_idx == LAST_BIT) begin
          bit_idx    <= '0;
          frame_stb  <= 1'b1;
          frame_err  <= !frame_ok(shreg_nx);
          frame_byte <= shreg_nx[DATA_BITS:1];
        end else begin
          bit_idx <= bit_idx + 1'b1;
        end
      end else if (gap_stb) begin
        bit_idx <= '0;
      end
    end
  end

  AST_DONE_AFTER_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    frame_stb |-> $past(clk_fall)); // R1
  AST_GAP_CLEARS_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    gap_stb |=> (bit_idx == '0)); // R9
  AST_BIT_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    clk_fall && (bit_idx == LAST_BIT) |=> frame_stb && (bit_idx == '0)); // R1
endmodule

// File: rtl/mpkt_assembler.sv
module mpkt_assembler
  import mpkt_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  frame_stb,
  input  logic                  frame_err,
  input  logic [DATA_BITS-1:0]  frame_byte,
  input  logic                  gap_stb,
  output logic                  left_btn,
  output logic                  right_btn,
  output logic [DELTA_BITS-1:0] delta_x,
  output logic [DELTA_BITS-1:0] delta_y,
  output logic                  ovf_x,
  output logic                  ovf_y,
  output logic                  pkt_valid
);
  slot_e                slot;
  logic [DATA_BITS-1:0] stat_q, x_q;
  logic                 good_frame, misalign;

  assign good_frame = frame_stb && !frame_err;
  assign misalign   = good_frame && (slot == SLOT_STAT) && !frame_byte[ST_SYNC];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slot      <= SLOT_STAT;
      stat_q    <= '0;
      x_q       <= '0;
      left_btn  <= 1'b0;
      right_btn <= 1'b0;
      delta_x   <= '0;
      delta_y   <= '0;
      ovf_x     <= 1'b0;
      ovf_y     <= 1'b0;
      pkt_valid <= 1'b0;
    end else begin
      pkt_valid <= 1'b0;
      if (gap_stb || (frame_stb && frame_err)) begin
        slot <= SLOT_STAT;
      end else if (good_frame) begin
        unique case (slot)
          SLOT_STAT: if (frame_byte[ST_SYNC]) begin
            stat_q <= frame_byte;
            slot   <= SLOT_X;
          end
          SLOT_X: begin
            x_q  <= frame_byte;
            slot <= SLOT_Y;
          end
          default: begin
            left_btn  <= stat_q[ST_LEFT];
            right_btn <= stat_q[ST_RIGHT];
            delta_x   <= to_delta(stat_q[ST_XSIGN], x_q);
            delta_y   <= to_delta(stat_q[ST_YSIGN], frame_byte);
            ovf_x     <= stat_q[ST_XOVF];
            ovf_y     <= stat_q[ST_YOVF];
            pkt_valid <= 1'b1;
            slot      <= SLOT_STAT;
          end
        endcase
      end
    end
  end

  AST_ONE_CYCLE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_valid |=> !pkt_valid); // R5
  AST_STROBE_FROM_Y: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_valid |-> $past(frame_stb) && $past(slot == SLOT_Y)); // R5
  AST_OUTPUTS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !pkt_valid |-> $stable({left_btn, right_btn, delta_x, delta_y, ovf_x, ovf_y})); // R5
  AST_BAD_FRAME_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    frame_stb && frame_err |=> (slot == SLOT_STAT) && !pkt_valid); // R6
  AST_MISALIGN_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    misalign |=> (slot == SLOT_STAT)); // R8
  AST_GAP_CLEARS_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    gap_stb |=> (slot == SLOT_STAT)); // R9
  AST_SLOT_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    slot != 2'd3); // R8
endmodule

// File: rtl/ps2_mouse_pkt_dec.sv
module ps2_mouse_pkt_dec
  import mpkt_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int GAP_CYCLES  = 200000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ps2_clk_i,
  input  logic       ps2_dat_i,
  output logic       left_btn,
  output logic       right_btn,
  output logic [8:0] delta_x,
  output logic [8:0] delta_y,
  output logic       ovf_x,
  output logic       ovf_y,
  output logic       pkt_valid
);
  logic                 clk_fall, dat_s;
  logic                 frame_stb, frame_err, gap_stb;
  logic [DATA_BITS-1:0] frame_byte;

  mpkt_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .ps2_clk(ps2_clk_i), .ps2_dat(ps2_dat_i),
    .clk_fall(clk_fall), .dat_s(dat_s)
  );

  mpkt_frame_rx #(.GAP_CYCLES(GAP_CYCLES)) u_frame (
    .clk(clk), .rst_n(rst_n), .clk_fall(clk_fall), .dat_s(dat_s),
    .frame_stb(frame_stb), .frame_err(frame_err), .frame_byte(frame_byte),
    .gap_stb(gap_stb)
  );

  mpkt_assembler u_asm (
    .clk(clk), .rst_n(rst_n), .frame_stb(frame_stb), .frame_err(frame_err),
    .frame_byte(frame_byte), .gap_stb(gap_stb),
    .left_btn(left_btn), .right_btn(right_btn), .delta_x(delta_x),
    .delta_y(delta_y), .ovf_x(ovf_x), .ovf_y(ovf_y), .pkt_valid(pkt_valid)
  );
endmodule

// File: tb/ps2_mouse_pkt_dec_test.sv
`timescale 1ns/1ps
module ps2_mouse_pkt_dec_test;
  localparam int GAP = 400;
  localparam int HP  = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ps2_c = 1'b1, ps2_d = 1'b1;
  logic lb, rb, ox, oy, pv;
  logic [8:0] dx, dy;
  int total = 0, bad = 0, pkts = 0, wide = 0;
  bit prev_pv = 0, done = 0;

  always #5 clk = ~clk;

  ps2_mouse_pkt_dec #(.SYNC_STAGES(2), .GAP_CYCLES(GAP)) uut (
    .clk(clk), .rst_n(rst_n), .ps2_clk_i(ps2_c), .ps2_dat_i(ps2_d),
    .left_btn(lb), .right_btn(rb), .delta_x(dx), .delta_y(dy),
    .ovf_x(ox), .ovf_y(oy), .pkt_valid(pv)
  );

  always @(negedge clk) begin
    if (pv) pkts++;
    if (pv && prev_pv) wide++;
    prev_pv = pv;
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    ps2_d = b;
    wait_cyc(HP);
    ps2_c = 1'b0;
    wait_cyc(HP);
    ps2_c = 1'b1;
  endtask

  task automatic send_frame(input logic [7:0] d, input bit flip_par, input bit bad_stop);
    send_bit(1'b0);
    for (int i = 0; i < 8; i++) send_bit(d[i]);
    send_bit((~^d) ^ flip_par);
    send_bit(~bad_stop);
    ps2_d = 1'b1;
    wait_cyc(60);
  endtask

  task automatic send_pkt(input logic [7:0] s, input logic [7:0] x, input logic [7:0] y);
    send_frame(s, 0, 0);
    send_frame(x, 0, 0);
    send_frame(y, 0, 0);
  endtask

  // expected values computed from the field rules in the requirements
  task automatic expect_pkt(input string tag, input logic [7:0] s,
                            input logic [7:0] x, input logic [7:0] y);
    int ex, ey;
    ex = int'(x) - (s[4] ? 256 : 0);
    ey = int'(y) - (s[5] ? 256 : 0);
    chk({tag, " R2 left"},  int'(lb), int'(s[0]));
    chk({tag, " R2 right"}, int'(rb), int'(s[1]));
    chk({tag, " R3 dx"},    int'($signed(dx)), ex);
    chk({tag, " R3 dy"},    int'($signed(dy)), ey);
    chk({tag, " R4 ovx"},   int'(ox), int'(s[6]));
    chk({tag, " R4 ovy"},   int'(oy), int'(s[7]));
  endtask

  task automatic t_reset;
    chk("R10 reset pv", int'(pv), 0);
    chk("R10 reset dx", int'(dx), 0);
    chk("R10 reset dy", int'(dy), 0);
    chk("R10 reset flags", int'({lb, rb, ox, oy}), 0);
  endtask

  task automatic t_basic;
    int p0 = pkts;
    send_pkt(8'h09, 8'h05, 8'h10);
    chk("R1 R5 one packet", pkts - p0, 1);
    expect_pkt("basic", 8'h09, 8'h05, 8'h10);
  endtask

  task automatic t_negative;
    int p0 = pkts;
    send_pkt(8'h3A, 8'hF0, 8'h80);
    chk("R3 neg packet", pkts - p0, 1);
    expect_pkt("neg", 8'h3A, 8'hF0, 8'h80);
  endtask

  task automatic t_overflow;
    int p0 = pkts;
    send_pkt(8'hC8, 8'hFF, 8'h01);
    chk("R4 ovf packet", pkts - p0, 1);
    expect_pkt("ovf", 8'hC8, 8'hFF, 8'h01);
  endtask

  task automatic t_hold;
    int p0 = pkts;
    wait_cyc(300);
    chk("R5 no extra strobe", pkts - p0, 0);
    expect_pkt("R5 hold", 8'hC8, 8'hFF, 8'h01);
  endtask

  task automatic t_parity;
    int p0 = pkts;
    send_frame(8'h18, 0, 0);
    send_frame(8'h40, 1, 0);
    chk("R6 no strobe after parity error", pkts - p0, 0);
    expect_pkt("R6 unchanged", 8'hC8, 8'hFF, 8'h01);
    send_pkt(8'h0A, 8'h03, 8'h04);
    chk("R6 recover count", pkts - p0, 1);
    expect_pkt("R6 recover", 8'h0A, 8'h03, 8'h04);
  endtask

  task automatic t_framing;
    int p0 = pkts;
    send_frame(8'h09, 0, 1);
    send_frame(8'h01, 0, 0);
    send_frame(8'h02, 0, 0);
    chk("R7 no strobe after stop error", pkts - p0, 0);
    expect_pkt("R7 unchanged", 8'h0A, 8'h03, 8'h04);
    send_pkt(8'h28, 8'h07, 8'hFE);
    chk("R7 recover count", pkts - p0, 1);
    expect_pkt("R7 recover", 8'h28, 8'h07, 8'hFE);
  endtask

  task automatic t_misalign;
    int p0 = pkts;
    send_frame(8'h00, 0, 0);
    chk("R8 stray byte no strobe", pkts - p0, 0);
    send_pkt(8'h0B, 8'h10, 8'h20);
    chk("R8 realigned count", pkts - p0, 1);
    expect_pkt("R8 realigned", 8'h0B, 8'h10, 8'h20);
  endtask

  task automatic t_gap_bytes;
    int p0 = pkts;
    send_frame(8'h08, 0, 0);
    send_frame(8'h11, 0, 0);
    wait_cyc(GAP + 100);
    send_pkt(8'h09, 8'h22, 8'h33);
    chk("R9 byte gap count", pkts - p0, 1);
    expect_pkt("R9 byte gap", 8'h09, 8'h22, 8'h33);
  endtask

  task automatic t_gap_bits;
    int p0 = pkts;
    send_bit(1'b0);
    send_bit(1'b1);
    send_bit(1'b1);
    send_bit(1'b0);
    send_bit(1'b1);
    ps2_d = 1'b1;
    wait_cyc(GAP + 100);
    send_pkt(8'h19, 8'h44, 8'h55);
    chk("R9 bit gap count", pkts - p0, 1);
    expect_pkt("R9 bit gap", 8'h19, 8'h44, 8'h55);
  endtask

  initial begin
    wait_cyc(5);
    rst_n = 1'b1;
    wait_cyc(3);
    t_reset();
    t_basic();
    t_negative();
    t_overflow();
    t_hold();
    t_parity();
    t_framing();
    t_misalign();
    t_gap_bytes();
    t_gap_bits();
    chk("R5 strobe width", wide, 0);
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule